// File: doc/BRIEF.md
# MDIO slave bridge to a paged 32-bit register bus

The block listens on a two-wire management bus (MDC clock, bidirectional MDIO data) as a Clause 22 slave and turns 16-bit transactions into accesses on an internal 32-bit register bus. The 5-bit PHY address field is not used as an address in the usual sense. Its top two bits choose what the frame does, and its low three bits are reused as register address bits. A page register, loaded by a dedicated frame type, provides the upper register address bits. This opens a 512-byte window per page into a 19-bit byte address space of 32-bit registers on a 4-byte stride. A third frame type forwards the access unchanged to a downstream PHY management port.

The high and low halves of each 32-bit register are reached separately. Writes are sent high half first. The high half is only staged, and the low-half write then commits the full word in one strobe, so any trigger bits in the low half act on a complete word. Reads are sent low half first. The low-half read fetches the whole word and keeps its upper half, and the following high-half read returns that kept value, so the pair always comes from one fetch. MDC and MDIO are sampled with the system clock, so MDC must be well below the system clock rate.

Top module: `mdio_reg_bridge`

## Requirements
- R1: Frames are recognised after any number of idle ones by a start pattern 0 then 1. The two opcode bits are 10 for read and 01 for write. A frame with opcode 00 or 11 produces no bus strobe and no change of state.
- R2: PHY address bits 4:3 select the mode: 3 loads the page, 2 accesses registers, 0 bypasses to a downstream PHY. Mode 1 is ignored: no strobe, MDIO is not driven, and the page is unchanged.
- R3: In register mode the byte address is {page, phy[2:0], reg[4:0], 0}. reg[0] (byte address bit 1) selects the upper halfword. The bus address is that byte address with bits 1:0 cleared.
- R4: A page-mode write loads data bits 9:0 into the page register. Reset clears the page to 0.
- R5: A page-mode read is not answered: MDIO stays undriven for the whole frame.
- R6: A register-mode write to the upper halfword (reg[0]=1) is staged only and produces no bus strobe.
- R7: A register-mode write to the lower halfword issues exactly one write strobe with data {staged upper half, written lower half}.
- R8: A register-mode read of the lower halfword issues exactly one read strobe, returns bits 15:0 of the fetched word, and keeps bits 31:16.
- R9: A register-mode read of the upper halfword returns the kept upper half and issues no read strobe.
- R10: On an answered read, the slave leaves the first turnaround bit undriven, drives 0 on the second, drives 16 data bits MSB first, and releases MDIO after the last data bit.
- R11: In bypass mode a read issues one PHY read strobe carrying phy[2:0] and reg and returns the PHY data. A write issues one PHY write strobe carrying the data.
- R12: After reset no strobe is active and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also clears the page |
| mdc_i | input | 1 | Management clock from the bus master |
| mdio_i | input | 1 | Management data as seen on the wire |
| mdio_o | output | 1 | Management data driven by the slave |
| mdio_oe_o | output | 1 | Drive enable for mdio_o |
| reg_we_o | output | 1 | Register write strobe, one clock |
| reg_re_o | output | 1 | Register read strobe, one clock; data sampled in the same clock |
| reg_addr_o | output | 19 | Register byte address, bits 1:0 zero |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data, valid while reg_re_o is high |
| phy_we_o | output | 1 | Downstream PHY write strobe |
| phy_re_o | output | 1 | Downstream PHY read strobe; data sampled in the same clock |
| phy_addr_o | output | 3 | Downstream PHY address |
| phy_reg_o | output | 5 | Downstream PHY register number |
| phy_wdata_o | output | 16 | Downstream PHY write data |
| phy_rdata_i | input | 16 | Downstream PHY read data |

## Verification
Properties checked on every cycle: at most one bus strobe is active at a time, the page only changes on a completed page write, each read fetch happens before the slave starts driving, the drive begins with a 0 turnaround bit, and drive is enabled only in the turnaround and data phases. Only the bench scenarios can show that the address bits come from the page, PHY and register fields, that the staged upper half is merged into the committed word, that the upper-half read returns the word fetched by the low-half read, and that reserved modes, bad opcodes and page reads leave the bus and the page untouched.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'd0,
    MODE_RSV  = 2'd1,
    MODE_REG  = 2'd2,
    MODE_PAGE = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_HDR,
    S_TA,
    S_DATA
  } fstate_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam int HDR_BITS = 12;
  localparam int HW_BITS  = 16;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic rise_o,
  output logic bit_o
);
  logic [SYNC_STAGES:0]   mdc_q;
  logic [SYNC_STAGES-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_q <= '0;
      dat_q <= '1;
    end else begin
      mdc_q <= {mdc_q[SYNC_STAGES-1:0], mdc_i};
      dat_q <= {dat_q[SYNC_STAGES-2:0], mdio_i};
    end
  end

  // data and clock pass the same number of flops, so they stay aligned
  assign rise_o = mdc_q[SYNC_STAGES-1] & ~mdc_q[SYNC_STAGES];
  assign bit_o  = dat_q[SYNC_STAGES-1];

  a_r1_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_bridge_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                bit_i,
  input  logic                resp_i,
  input  logic [HW_BITS-1:0]  rd_word_i,
  output logic                hdr_done_o,
  output logic                wr_done_o,
  output logic [1:0]          op_o,
  output logic [4:0]          phy_o,
  output logic [4:0]          reg_o,
  output logic [HW_BITS-1:0]  wdata_o,
  output logic                mdio_o,
  output logic                mdio_oe_o
);
  fstate_e               state_q;
  logic [3:0]            cnt_q;
  logic [HDR_BITS-1:0]   hdr_q;
  logic [HW_BITS-1:0]    sh_q;
  logic [HW_BITS-1:0]    wdata_q;
  logic                  obit_q, oe_q, hdr_done_q, wr_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      hdr_q      <= '0;
      sh_q       <= '0;
      wdata_q    <= '0;
      obit_q     <= 1'b1;
      oe_q       <= 1'b0;
      hdr_done_q <= 1'b0;
      wr_done_q  <= 1'b0;
    end else begin
      hdr_done_q <= 1'b0;
      wr_done_q  <= 1'b0;
      if (rise_i) begin
        unique case (state_q)
          S_IDLE: if (!bit_i) state_q <= S_START;
          S_START: begin
            if (bit_i) begin
              state_q <= S_HDR;
              cnt_q   <= '0;
            end
          end
          S_HDR: begin
            hdr_q <= {hdr_q[HDR_BITS-2:0], bit_i};
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'(HDR_BITS - 1)) begin
              state_q    <= S_TA;
              cnt_q      <= '0;
              hdr_done_q <= 1'b1;
            end
          end
          S_TA: begin
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd0) begin
              if (hdr_q[HDR_BITS-1 -: 2] == OP_RD && resp_i) begin
                oe_q   <= 1'b1;
                obit_q <= 1'b0;
              end
            end else begin
              state_q <= S_DATA;
              cnt_q   <= '0;
              sh_q    <= {rd_word_i[HW_BITS-2:0], 1'b0};
              obit_q  <= rd_word_i[HW_BITS-1];
            end
          end
          S_DATA: begin
            obit_q <= sh_q[HW_BITS-1];
            sh_q   <= {sh_q[HW_BITS-2:0], bit_i};
            cnt_q  <= cnt_q + 4'd1;
            if (cnt_q == 4'(HW_BITS - 1)) begin
              state_q   <= S_IDLE;
              oe_q      <= 1'b0;
              obit_q    <= 1'b1;
              wr_done_q <= (hdr_q[HDR_BITS-1 -: 2] == OP_WR);
              wdata_q   <= {sh_q[HW_BITS-2:0], bit_i};
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign hdr_done_o = hdr_done_q;
  assign wr_done_o  = wr_done_q;
  assign op_o       = hdr_q[11:10];
  assign phy_o      = hdr_q[9:5];
  assign reg_o      = hdr_q[4:0];
  assign wdata_o    = wdata_q;
  assign mdio_o     = obit_q;
  assign mdio_oe_o  = oe_q;

  a_r10_ta_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);
  a_r10_drive_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> (state_q == S_TA || state_q == S_DATA));
endmodule

// File: rtl/mdio_addr_map.sv
module mdio_addr_map
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  localparam int ADDR_W = PAGE_W + 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hdr_done_i,
  input  logic                 wr_done_i,
  input  logic [1:0]           op_i,
  input  logic [4:0]           phy_i,
  input  logic [4:0]           reg_i,
  input  logic [HW_BITS-1:0]   wdata_i,
  output logic                 resp_o,
  output logic [HW_BITS-1:0]   rd_word_o,
  output logic                 reg_we_o,
  output logic                 reg_re_o,
  output logic [ADDR_W-1:0]    reg_addr_o,
  output logic [2*HW_BITS-1:0] reg_wdata_o,
  input  logic [2*HW_BITS-1:0] reg_rdata_i,
  output logic                 phy_we_o,
  output logic                 phy_re_o,
  output logic [2:0]           phy_addr_o,
  output logic [4:0]           phy_reg_o,
  output logic [HW_BITS-1:0]   phy_wdata_o,
  input  logic [HW_BITS-1:0]   phy_rdata_i
);
  mode_e               mode;
  logic                is_rd, is_wr, upper;
  logic [PAGE_W-1:0]   page_q;
  logic [HW_BITS-1:0]  stage_q, hi_q, rd_word_q;
  logic                resp_q;

  assign mode  = mode_e'(phy_i[4:3]);
  assign is_rd = (op_i == OP_RD);
  assign is_wr = (op_i == OP_WR);
  assign upper = reg_i[0];

  always_comb begin
    reg_re_o = hdr_done_i && is_rd && mode == MODE_REG && !upper;
    phy_re_o = hdr_done_i && is_rd && mode == MODE_BYP;
    reg_we_o = wr_done_i && is_wr && mode == MODE_REG && !upper;
    phy_we_o = wr_done_i && is_wr && mode == MODE_BYP;
  end

  assign reg_addr_o  = {page_q, phy_i[2:0], reg_i[4:1], 2'b00};
  assign reg_wdata_o = {stage_q, wdata_i};
  assign phy_addr_o  = phy_i[2:0];
  assign phy_reg_o   = reg_i;
  assign phy_wdata_o = wdata_i;
  assign resp_o      = resp_q;
  assign rd_word_o   = rd_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q    <= '0;
      stage_q   <= '0;
      hi_q      <= '0;
      rd_word_q <= '0;
      resp_q    <= 1'b0;
    end else begin
      if (hdr_done_i) begin
        resp_q <= is_rd && (mode == MODE_REG || mode == MODE_BYP);
        if (reg_re_o) begin
          rd_word_q <= reg_rdata_i[HW_BITS-1:0];
          hi_q      <= reg_rdata_i[2*HW_BITS-1:HW_BITS];
        end else if (is_rd && mode == MODE_REG) begin
          rd_word_q <= hi_q;
        end else if (phy_re_o) begin
          rd_word_q <= phy_rdata_i;
        end
      end
      if (wr_done_i && is_wr) begin
        if (mode == MODE_REG && upper) stage_q <= wdata_i;
        if (mode == MODE_PAGE)         page_q  <= wdata_i[PAGE_W-1:0];
      end
    end
  end

  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o, phy_we_o, phy_re_o}));
  a_r4_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_done_i && is_wr && mode == MODE_PAGE) |=> $stable(page_q));
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = PAGE_W + 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [31:0]       reg_wdata_o,
  input  logic [31:0]       reg_rdata_i,
  output logic              phy_we_o,
  output logic              phy_re_o,
  output logic [2:0]        phy_addr_o,
  output logic [4:0]        phy_reg_o,
  output logic [15:0]       phy_wdata_o,
  input  logic [15:0]       phy_rdata_i
);
  logic               rise, sbit, hdr_done, wr_done, resp;
  logic [1:0]         op;
  logic [4:0]         phy, rg;
  logic [HW_BITS-1:0] wdata, rd_word;

  mdio_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .mdc_i, .mdio_i,
    .rise_o (rise),
    .bit_o  (sbit)
  );

  mdio_frame u_frame (
    .clk_i, .rst_ni,
    .rise_i     (rise),
    .bit_i      (sbit),
    .resp_i     (resp),
    .rd_word_i  (rd_word),
    .hdr_done_o (hdr_done),
    .wr_done_o  (wr_done),
    .op_o       (op),
    .phy_o      (phy),
    .reg_o      (rg),
    .wdata_o    (wdata),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  mdio_addr_map #(.PAGE_W(PAGE_W)) u_map (
    .clk_i, .rst_ni,
    .hdr_done_i  (hdr_done),
    .wr_done_i   (wr_done),
    .op_i        (op),
    .phy_i       (phy),
    .reg_i       (rg),
    .wdata_i     (wdata),
    .resp_o      (resp),
    .rd_word_o   (rd_word),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i),
    .phy_we_o    (phy_we_o),
    .phy_re_o    (phy_re_o),
    .phy_addr_o  (phy_addr_o),
    .phy_reg_o   (phy_reg_o),
    .phy_wdata_o (phy_wdata_o),
    .phy_rdata_i (phy_rdata_i)
  );

  // the word must be fetched before the turnaround drive starts
  a_r8_fetch_before_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> !mdio_oe_o);
endmodule

// File: tb/sim_mdio_reg_bridge.sv
module sim_mdio_reg_bridge;
  localparam int HP = 8;
  localparam int AW = 19;

  logic clk = 1'b0, rst_ni = 1'b0, mdc = 1'b0;
  logic m_drive = 1'b1, m_bit = 1'b1;
  logic mdio_o, mdio_oe, mdio_line;
  logic reg_we, reg_re, phy_we, phy_re;
  logic [AW-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0] phy_addr;
  logic [4:0] phy_reg;
  logic [15:0] phy_wdata, phy_rdata;

  int n_chk = 0, n_fail = 0;
  int n_we = 0, n_re = 0, n_pwe = 0, n_pre = 0;
  logic [AW-1:0] last_we_addr, last_re_addr;
  logic [31:0] last_wdata;
  logic [2:0] last_paddr;
  logic [4:0] last_preg;
  logic [15:0] last_pwdata;
  bit oe_seen;

  always #4 clk = ~clk;

  function automatic logic [31:0] rmodel(input logic [AW-1:0] a);
    return {a[18:3] ^ 16'h3C3C, a[15:0] ^ 16'h0F0F};
  endfunction

  assign mdio_line = mdio_oe ? mdio_o : (m_drive ? m_bit : 1'b1);
  assign reg_rdata = rmodel(reg_addr);
  assign phy_rdata = {phy_addr, phy_reg, 8'h5A};

  mdio_reg_bridge u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mdc_i(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .phy_we_o(phy_we), .phy_re_o(phy_re), .phy_addr_o(phy_addr),
    .phy_reg_o(phy_reg), .phy_wdata_o(phy_wdata), .phy_rdata_i(phy_rdata)
  );

  always @(posedge clk) begin
    if (mdio_oe) oe_seen <= 1'b1;
    if (reg_we) begin n_we <= n_we + 1; last_we_addr <= reg_addr; last_wdata <= reg_wdata; end
    if (reg_re) begin n_re <= n_re + 1; last_re_addr <= reg_addr; end
    if (phy_we) begin n_pwe <= n_pwe + 1; last_pwdata <= phy_wdata; end
    if (phy_re) begin n_pre <= n_pre + 1; last_paddr <= phy_addr; last_preg <= phy_reg; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input bit drv, input bit b, output bit s);
    m_drive = drv;
    m_bit   = b;
    mdc     = 1'b0;
    repeat (HP) @(negedge clk);
    s   = mdio_line;
    mdc = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wd, output logic [15:0] rd, output bit ta0);
    bit s;
    logic [13:0] hdr;
    bit rdop;
    rdop = (op == 2'b10);
    hdr  = {2'b01, op, phy, rg};
    @(negedge clk);
    oe_seen = 1'b0;
    for (int i = 0; i < 32; i++) bit_cycle(1'b1, 1'b1, s);
    for (int i = 13; i >= 0; i--) bit_cycle(1'b1, hdr[i], s);
    bit_cycle(!rdop, 1'b1, s);
    bit_cycle(!rdop, 1'b0, s);
    ta0 = rdop && (s == 1'b0);
    for (int i = 15; i >= 0; i--) begin
      bit_cycle(!rdop, wd[i], s);
      rd[i] = s;
    end
    for (int i = 0; i < 2; i++) bit_cycle(1'b1, 1'b1, s);
  endtask

  localparam logic [38:0] VEC [4] = '{
    {10'h000, 5'b10000, 5'b00000, 19'h00000},
    {10'h000, 5'b10101, 5'b01010, 19'h00154},
    {10'h3FF, 5'b10111, 5'b11110, 19'h7FFFC},
    {10'h155, 5'b10010, 5'b00100, 19'h2AA88}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    bit ta0;
    int we0, re0, pre0, pwe0;
    repeat (5) @(negedge clk);
    // R12 reset state
    check(!mdio_oe && !reg_we && !reg_re && !phy_we && !phy_re, "R12",
          {mdio_oe, reg_we, reg_re, phy_we, phy_re}, 32'h0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // table: page load, low read (R3 R8 R10), high read (R9)
    for (int v = 0; v < 4; v++) begin
      logic [9:0] pg;
      logic [4:0] ph, rr;
      logic [AW-1:0] ea;
      {pg, ph, rr, ea} = VEC[v];
      xfer(2'b01, 5'b11000, 5'd0, {6'd0, pg}, rd, ta0);
      re0 = n_re;
      xfer(2'b10, ph, rr, 16'h0, rd, ta0);
      check(n_re == re0 + 1, "R8", n_re - re0, 1);
      check(last_re_addr == ea, "R3", last_re_addr, ea);
      check(rd == rmodel(ea)[15:0], "R8", rd, rmodel(ea)[15:0]);
      check(ta0, "R10", ta0, 1);
      check(!mdio_oe, "R10", mdio_oe, 0);
      re0 = n_re;
      xfer(2'b10, ph, rr | 5'd1, 16'h0, rd, ta0);
      check(n_re == re0, "R9", n_re - re0, 0);
      check(rd == rmodel(ea)[31:16], "R9", rd, rmodel(ea)[31:16]);
    end

    // R6 R7 write pair on page 1
    xfer(2'b01, 5'b11000, 5'd0, 16'h0001, rd, ta0);
    we0 = n_we;
    xfer(2'b01, 5'b10000, 5'b00011, 16'hBEEF, rd, ta0);
    check(n_we == we0, "R6", n_we - we0, 0);
    xfer(2'b01, 5'b10000, 5'b00010, 16'hCAFE, rd, ta0);
    check(n_we == we0 + 1, "R7", n_we - we0, 1);
    check(last_we_addr == 19'h00204, "R7", last_we_addr, 19'h00204);
    check(last_wdata == 32'hBEEFCAFE, "R7", last_wdata, 32'hBEEFCAFE);

    // R5 page read unanswered
    xfer(2'b10, 5'b11000, 5'd0, 16'h0, rd, ta0);
    check(!oe_seen, "R5", oe_seen, 0);
    check(rd == 16'hFFFF, "R5", rd, 16'hFFFF);

    // R2 reserved mode: no drive, no strobe, page kept
    we0 = n_we; re0 = n_re; pre0 = n_pre; pwe0 = n_pwe;
    xfer(2'b10, 5'b01000, 5'd4, 16'h0, rd, ta0);
    check(!oe_seen, "R2", oe_seen, 0);
    xfer(2'b01, 5'b01011, 5'd0, 16'h03FF, rd, ta0);
    // R1 bad opcodes aimed at the page
    xfer(2'b00, 5'b11000, 5'd0, 16'h0077, rd, ta0);
    xfer(2'b11, 5'b11000, 5'd0, 16'h0066, rd, ta0);
    check(n_we == we0 && n_re == re0 && n_pre == pre0 && n_pwe == pwe0, "R1",
          n_we + n_re + n_pre + n_pwe, we0 + re0 + pre0 + pwe0);
    xfer(2'b10, 5'b10000, 5'd0, 16'h0, rd, ta0);
    check(last_re_addr == 19'h00200, "R2", last_re_addr, 19'h00200);

    // R11 bypass
    pre0 = n_pre;
    xfer(2'b10, 5'b00011, 5'd7, 16'h0, rd, ta0);
    check(n_pre == pre0 + 1, "R11", n_pre - pre0, 1);
    check({last_paddr, last_preg} == {3'd3, 5'd7}, "R11", {last_paddr, last_preg}, {3'd3, 5'd7});
    check(rd == {3'd3, 5'd7, 8'h5A}, "R11", rd, {3'd3, 5'd7, 8'h5A});
    pwe0 = n_pwe;
    xfer(2'b01, 5'b00110, 5'd9, 16'h1357, rd, ta0);
    check(n_pwe == pwe0 + 1 && last_pwdata == 16'h1357, "R11", last_pwdata, 16'h1357);

    // R4 reset clears page
    xfer(2'b01, 5'b11000, 5'd0, 16'h00AB, rd, ta0);
    xfer(2'b10, 5'b10000, 5'd0, 16'h0, rd, ta0);
    check(last_re_addr == {10'h0AB, 9'h0}, "R4", last_re_addr, {10'h0AB, 9'h0});
    @(negedge clk); rst_ni = 1'b0;
    repeat (4) @(negedge clk); rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    xfer(2'b10, 5'b10000, 5'd0, 16'h0, rd, ta0);
    check(last_re_addr == 19'h0, "R4", last_re_addr, 19'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule